// File: doc/BRIEF.md
# Framed Receive Queue with Per-Word and Per-Frame Status

This block sits behind the line decoder of a framed serial receiver. Each accepted data byte enters a 16-deep FIFO together with its own error flags and a last-of-frame marker. When a frame closes, the block writes a one-record summary of that frame to a separate 4-deep queue. A frame closes on its last byte, on an abort from the far end, or on an overrun. Because the summaries queue separately from the data, a new frame can arrive while software is still working through an earlier one.

Software uses a small register read port. A flag register shows the error state of the byte at the head of the FIFO. Reading the data register pops that byte. Reading the summary register pops one frame record. A status register shows the FIFO fill level and a sticky summary-overflow bit. Two interrupts are provided. The service interrupt is a level that is high while any byte is waiting. The frame-complete interrupt is sticky and rises only when the final byte of a frame leaves the FIFO.

Top module: `rxq_top`

## Requirements
- R1: Accepted bytes are read back in arrival order. A read of the data register (address 1) returns the head byte in bits [7:0] and pops it. A read of the data register while the FIFO is empty returns 0 and changes nothing.
- R2: The flag register (address 0) shows the head entry. Bits [3:0] are the error flags: bit0 abort, bit1 overrun, bit2 CRC mismatch, bit3 framing error. Bit 4 is the last-of-frame marker and bit 5 is the entry-valid bit. The register reads 0 when the FIFO is empty. After each pop, the register shows the next entry.
- R3: `irq_svc` is high exactly while the FIFO holds at least one byte.
- R4: `irq_done` rises in the cycle after a read of the data register that pops an entry marked last-of-frame. Writing that entry into the FIFO does not raise it.
- R5: The summary register (address 2) returns the byte count in bits [10:0], the error flags in bits [14:11] (bit11 abort, bit12 overrun, bit13 CRC, bit14 framing) and a valid bit in bit 15. It returns 0 when the queue is empty. Any read of it clears `irq_done`, and a read of a valid record pops that record.
- R6: The `in_crc_err` and `in_frm_err` inputs apply to the byte that carries `in_last`. They set the CRC and framing flags of that entry and of its frame summary, and they never raise an interrupt by themselves.
- R7: A byte offered while 16 bytes are held is dropped. The newest stored byte of that frame becomes last-of-frame and gains the overrun flag. The summary records the stored count with the overrun bit set. Every later byte is discarded until a byte arrives with `in_sof` set.
- R8: `in_abort` while a frame is open closes it. The newest stored byte of that frame becomes last-of-frame with the abort flag, and the summary gets the abort bit. `in_abort` while no frame is open is ignored.
- R9: While `rx_en` is low, no byte is accepted and `in_abort` has no effect.
- R10: Up to 4 unread summaries are kept. If a frame closes while 4 are waiting, its summary is dropped and status bit 5 is set. Status (address 3) bits [4:0] give the FIFO fill level. Reading status clears bit 5.
- R11: If an abort or overrun closes a frame whose bytes have all been read already, `irq_done` rises in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| in_valid | input | 1 | A byte is offered this cycle |
| in_data | input | 8 | Offered byte |
| in_sof | input | 1 | Offered byte starts a frame |
| in_last | input | 1 | Offered byte ends a frame |
| in_crc_err | input | 1 | CRC mismatch for the frame ending with this byte |
| in_frm_err | input | 1 | Framing error for the frame ending with this byte |
| in_abort | input | 1 | Far end aborted the current frame |
| rd_en | input | 1 | Register read strobe (side effects on this edge) |
| rd_addr | input | 2 | 0 flags, 1 data, 2 summary, 3 status |
| rd_data | output | 16 | Read data, combinational from `rd_addr` and state |
| irq_svc | output | 1 | Bytes are waiting |
| irq_done | output | 1 | Frame-complete, sticky |

## Verification
Each input is captured on one rising edge, and its effect on the FIFO, queue and interrupts shows up right after that edge. `rd_data` is combinational from the state and `rd_addr`, so the bench sets the address, waits briefly, and samples the value before it pulses `rd_en`. After a popping read, `irq_done` is checked at the next falling edge, one cycle after the pop. It is also checked while the frame's last byte is still queued, where it must still be low. The interrupt triggered by an abort on a frame whose bytes have all been read is likewise checked one edge after the abort cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int DW = 8;
    localparam int CW = 11;

    // bit0 abort, bit1 overrun, bit2 crc, bit3 framing
    typedef struct packed {
        logic frm;
        logic crc;
        logic ovr;
        logic abt;
    } rxq_err_t;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          last;
        rxq_err_t      err;
    } rxq_ent_t;

    typedef struct packed {
        logic [CW-1:0] len;
        rxq_err_t      err;
    } rxq_sum_t;

    typedef enum logic [1:0] {
        REG_FLAG = 2'd0,
        REG_DATA = 2'd1,
        REG_SUM  = 2'd2,
        REG_STAT = 2'd3
    } rxq_reg_e;

    function automatic logic [CW-1:0] len_inc(input logic [CW-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNTW = AW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  rxq_ent_t        push_ent,
    input  logic            pop,
    input  logic            mark,
    input  rxq_err_t        mark_err,
    output rxq_ent_t        head,
    output logic [CNTW-1:0] cnt
);
    rxq_ent_t        mem [DEPTH];
    logic [AW-1:0]   wp, rp, tail;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign tail = (wp == '0) ? AW'(DEPTH - 1) : wp - 1'b1;
    assign head = mem[rp];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= push_ent;
        end else if (mark) begin
            mem[tail].last <= 1'b1;
            mem[tail].err  <= rxq_err_t'(mem[tail].err | mark_err);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            cnt <= cnt + CNTW'(push) - CNTW'(pop);
        end
    end
endmodule

// File: rtl/rxq_sumq.sv
module rxq_sumq
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNTW = AW + 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rxq_sum_t push_rec,
    input  logic     pop,
    output rxq_sum_t head,
    output logic     valid,
    output logic     full
);
    rxq_sum_t        mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CNTW-1:0] cnt;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = mem[rp];
    assign valid = (cnt != '0);
    assign full  = (cnt == CNTW'(DEPTH));

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_rec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            cnt <= cnt + CNTW'(push) - CNTW'(pop);
        end
    end
endmodule

// File: rtl/rxq_frame.sv
module rxq_frame
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNTW = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_en,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_data,
    input  logic            in_sof,
    input  logic            in_last,
    input  logic            in_crc_err,
    input  logic            in_frm_err,
    input  logic            in_abort,
    input  logic [CNTW-1:0] fifo_cnt,
    input  logic            fifo_pop,
    input  logic            sum_room,
    output logic            push,
    output rxq_ent_t        push_ent,
    output logic            mark,
    output rxq_err_t        mark_err,
    output logic            sum_push,
    output rxq_sum_t        sum_rec,
    output logic            done_now,
    output logic            ovf_set
);
    logic            in_frame, discard;
    logic [CW-1:0]   len;
    logic [CNTW-1:0] pend;

    logic            in_frame_n, discard_n;
    logic [CW-1:0]   len_n, base, grown;
    logic [CNTW-1:0] pend_n, pend_after;
    logic            abort_now, take, full, pend_dec, sum_req;
    rxq_err_t        word_err, abt_err, ovr_err;

    always_comb begin
        abort_now  = rx_en && in_abort && in_frame;
        take       = rx_en && in_valid && !abort_now && (!discard || in_sof);
        full       = (fifo_cnt == CNTW'(DEPTH));
        // the open frame's bytes are the newest pend entries of the FIFO
        pend_dec   = fifo_pop && (fifo_cnt == pend);
        pend_after = pend - CNTW'(pend_dec);
        base       = in_frame ? len : '0;
        grown      = len_inc(base);

        word_err     = '0;
        word_err.crc = in_last && in_crc_err;
        word_err.frm = in_last && in_frm_err;
        abt_err      = '0;
        abt_err.abt  = 1'b1;
        ovr_err      = '0;
        ovr_err.ovr  = 1'b1;

        push       = 1'b0;
        push_ent   = '0;
        mark       = 1'b0;
        mark_err   = '0;
        sum_req    = 1'b0;
        sum_rec    = '0;
        done_now   = 1'b0;
        in_frame_n = in_frame;
        discard_n  = discard;
        len_n      = len;
        pend_n     = pend_after;

        if (abort_now || (take && full)) begin
            sum_req     = 1'b1;
            sum_rec.len = base;
            sum_rec.err = abort_now ? abt_err : ovr_err;
            if (pend_after != '0) begin
                mark     = 1'b1;
                mark_err = sum_rec.err;
            end else begin
                done_now = 1'b1;
            end
            discard_n  = abort_now ? discard : !in_last;
            in_frame_n = 1'b0;
            len_n      = '0;
            pend_n     = '0;
        end else if (take) begin
            push          = 1'b1;
            push_ent.data = in_data;
            push_ent.last = in_last;
            push_ent.err  = word_err;
            discard_n     = 1'b0;
            if (in_last) begin
                sum_req     = 1'b1;
                sum_rec.len = grown;
                sum_rec.err = word_err;
                in_frame_n  = 1'b0;
                len_n       = '0;
                pend_n      = '0;
            end else begin
                in_frame_n  = 1'b1;
                len_n       = grown;
                pend_n      = pend_after + 1'b1;
            end
        end

        sum_push = sum_req && sum_room;
        ovf_set  = sum_req && !sum_room;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            discard  <= 1'b0;
            len      <= '0;
            pend     <= '0;
        end else begin
            in_frame <= in_frame_n;
            discard  <= discard_n;
            len      <= len_n;
            pend     <= pend_n;
        end
    end
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int SDEPTH = 4,
    localparam int CNTW  = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_en,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_last,
    input  logic        in_crc_err,
    input  logic        in_frm_err,
    input  logic        in_abort,
    input  logic        rd_en,
    input  logic [1:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic        irq_svc,
    output logic        irq_done
);
    logic [CNTW-1:0] fifo_cnt;
    rxq_ent_t        head, push_ent;
    rxq_err_t        mark_err;
    rxq_sum_t        sum_head, sum_rec;
    logic            push, mark, sum_push, done_now, ovf_set;
    logic            sum_vld, sum_full, sum_room;
    logic            fifo_pop, sum_pop, sum_rd, stat_rd, head_last, sum_ovf;

    assign head_last = head.last;
    assign irq_svc   = (fifo_cnt != '0);
    assign fifo_pop  = rd_en && (rd_addr == REG_DATA) && irq_svc;
    assign sum_rd    = rd_en && (rd_addr == REG_SUM);
    assign sum_pop   = sum_rd && sum_vld;
    assign stat_rd   = rd_en && (rd_addr == REG_STAT);
    assign sum_room  = !sum_full || sum_pop;

    rxq_frame #(.DEPTH(DEPTH)) u_frame (
        .clk(clk), .rst(rst), .rx_en(rx_en), .in_valid(in_valid),
        .in_data(in_data), .in_sof(in_sof), .in_last(in_last),
        .in_crc_err(in_crc_err), .in_frm_err(in_frm_err), .in_abort(in_abort),
        .fifo_cnt(fifo_cnt), .fifo_pop(fifo_pop), .sum_room(sum_room),
        .push(push), .push_ent(push_ent), .mark(mark), .mark_err(mark_err),
        .sum_push(sum_push), .sum_rec(sum_rec), .done_now(done_now),
        .ovf_set(ovf_set)
    );

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_ent(push_ent),
        .pop(fifo_pop), .mark(mark), .mark_err(mark_err),
        .head(head), .cnt(fifo_cnt)
    );

    rxq_sumq #(.DEPTH(SDEPTH)) u_sumq (
        .clk(clk), .rst(rst), .push(sum_push), .push_rec(sum_rec),
        .pop(sum_pop), .head(sum_head), .valid(sum_vld), .full(sum_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_done <= 1'b0;
            sum_ovf  <= 1'b0;
        end else begin
            if (done_now || (fifo_pop && head_last)) irq_done <= 1'b1;
            else if (sum_rd)                         irq_done <= 1'b0;
            if (ovf_set)      sum_ovf <= 1'b1;
            else if (stat_rd) sum_ovf <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rxq_reg_e'(rd_addr))
            REG_FLAG: if (irq_svc) rd_data = {10'b0, 1'b1, head.last, head.err};
            REG_DATA: if (irq_svc) rd_data = {8'b0, head.data};
            REG_SUM:  if (sum_vld) rd_data = {1'b1, sum_head.err, sum_head.len};
            REG_STAT: begin
                rd_data[5]   = sum_ovf;
                rd_data[4:0] = 5'(fifo_cnt);
            end
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 16,
    localparam int CNTW = $clog2(DEPTH) + 1
) (
    input logic            clk,
    input logic            rst,
    input logic            rx_en,
    input logic            rd_en,
    input logic [1:0]      rd_addr,
    input logic [CNTW-1:0] fifo_cnt,
    input logic            head_last,
    input logic            irq_done,
    input logic            sum_ovf
);
    a_r1_depth_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNTW'(DEPTH));

    a_r4_done_after_last_pop: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == 2'd1 && fifo_cnt != '0 && head_last) |=> irq_done);

    a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_done && !(rd_en && rd_addr == 2'd2)) |=> irq_done);

    a_r9_no_growth_disabled: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (fifo_cnt <= $past(fifo_cnt)));

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (sum_ovf && !(rd_en && rd_addr == 2'd3)) |=> sum_ovf);
endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rd_en(rd_en), .rd_addr(rd_addr),
    .fifo_cnt(fifo_cnt), .head_last(head_last), .irq_done(irq_done),
    .sum_ovf(sum_ovf)
);

// File: tb/test_rxq_top.sv
module test_rxq_top;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        rx_en = 0, in_valid = 0, in_sof = 0, in_last = 0;
    logic        in_crc_err = 0, in_frm_err = 0, in_abort = 0;
    logic [7:0]  in_data = 0;
    logic        rd_en = 0;
    logic [1:0]  rd_addr = 0;
    logic [15:0] rd_data;
    logic        irq_svc, irq_done;

    int total = 0, bad = 0;
    logic [15:0] exp_flag[$], exp_sum[$];
    logic [7:0]  exp_data[$];

    always #(CLK_P/2) clk = ~clk;

    rxq_top i_rxq_top (
        .clk(clk), .rst(rst), .rx_en(rx_en), .in_valid(in_valid),
        .in_data(in_data), .in_sof(in_sof), .in_last(in_last),
        .in_crc_err(in_crc_err), .in_frm_err(in_frm_err), .in_abort(in_abort),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_svc(irq_svc), .irq_done(irq_done)
    );

    function automatic logic [15:0] flag_of(input bit last, input bit abt,
        input bit ovr, input bit crc, input bit frm);
        return 16'h20 | (last ? 16'h10 : 16'h0) | (abt ? 16'h1 : 16'h0)
             | (ovr ? 16'h2 : 16'h0) | (crc ? 16'h4 : 16'h0) | (frm ? 16'h8 : 16'h0);
    endfunction

    function automatic logic [15:0] sum_of(input int len, input bit abt,
        input bit ovr, input bit crc, input bit frm);
        return 16'h8000 | (abt ? 16'h0800 : 16'h0) | (ovr ? 16'h1000 : 16'h0)
             | (crc ? 16'h2000 : 16'h0) | (frm ? 16'h4000 : 16'h0) | 16'(len);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input bit sof, input bit last,
        input bit crc, input bit frm);
        in_valid = 1; in_data = d; in_sof = sof; in_last = last;
        in_crc_err = crc; in_frm_err = frm;
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_last = 0; in_crc_err = 0; in_frm_err = 0;
    endtask

    task automatic abort_pulse();
        in_abort = 1;
        @(negedge clk);
        in_abort = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
    endtask

    // pops the model head and compares flags, data, interrupt and summary
    task automatic pop_check();
        logic [15:0] v, ef;
        ef = exp_flag.pop_front();
        peek(2'd0, v);
        check("R2 head flags", v, ef);
        rd(2'd1, v);
        check("R1 head data", v, {8'h0, exp_data.pop_front()});
        check("R3 svc level", 16'(irq_svc), 16'(exp_data.size() != 0));
        if (ef[4]) begin
            check("R4 done after last pop", 16'(irq_done), 16'h1);
            rd(2'd2, v);
            check("R5 summary", v, exp_sum.pop_front());
            check("R5 done cleared", 16'(irq_done), 16'h0);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // reset state
        peek(2'd0, v); check("R2 reset flags", v, 16'h0);
        peek(2'd1, v); check("R1 reset data", v, 16'h0);
        peek(2'd2, v); check("R5 reset summary", v, 16'h0);
        peek(2'd3, v); check("R10 reset status", v, 16'h0);
        check("R3 reset svc", 16'(irq_svc), 16'h0);
        check("R4 reset done", 16'(irq_done), 16'h0);

        // R9: disabled receiver ignores bytes and aborts
        send(8'h11, 1, 1, 0, 0);
        abort_pulse();
        peek(2'd3, v); check("R9 nothing taken", v, 16'h0);
        check("R9 svc low", 16'(irq_svc), 16'h0);
        rx_en = 1;

        // R4/R6: crc error on last byte, no interrupt at arrival
        send(8'hA1, 1, 0, 0, 0);
        send(8'hB2, 0, 0, 0, 0);
        send(8'hC3, 0, 1, 1, 0);
        check("R6 no irq from error", 16'(irq_done), 16'h0);
        check("R3 svc high", 16'(irq_svc), 16'h1);
        exp_data = '{8'hA1, 8'hB2, 8'hC3};
        exp_flag = '{flag_of(0,0,0,0,0), flag_of(0,0,0,0,0), flag_of(1,0,0,1,0)};
        exp_sum  = '{sum_of(3,0,0,1,0)};
        pop_check(); pop_check();
        check("R4 not before last pop", 16'(irq_done), 16'h0);
        pop_check();
        rd(2'd1, v); check("R1 empty data read", v, 16'h0);

        // R7: overrun
        for (int k = 0; k < 16; k++) send(8'(k + 8'h40), k == 0, 0, 0, 0);
        send(8'hEE, 0, 0, 0, 0);
        send(8'hEF, 0, 0, 0, 0);
        peek(2'd3, v); check("R7 full, extra dropped", v, 16'h0010);
        check("R7 no irq at overrun", 16'(irq_done), 16'h0);
        for (int k = 0; k < 16; k++) begin
            exp_data.push_back(8'(k + 8'h40));
            exp_flag.push_back(flag_of(k == 15, 0, k == 15, 0, 0));
        end
        exp_sum.push_back(sum_of(16, 0, 1, 0, 0));
        repeat (16) pop_check();
        send(8'h77, 0, 1, 0, 0);
        peek(2'd3, v); check("R7 discard until sof", v, 16'h0);
        send(8'h78, 1, 1, 0, 1);
        exp_data.push_back(8'h78);
        exp_flag.push_back(flag_of(1, 0, 0, 0, 1));
        exp_sum.push_back(sum_of(1, 0, 0, 0, 1));
        pop_check();

        // R8: abort with bytes queued
        send(8'h21, 1, 0, 0, 0);
        send(8'h22, 0, 0, 0, 0);
        abort_pulse();
        exp_data = '{8'h21, 8'h22};
        exp_flag = '{flag_of(0,0,0,0,0), flag_of(1,1,0,0,0)};
        exp_sum  = '{sum_of(2,1,0,0,0)};
        pop_check(); pop_check();
        abort_pulse();
        peek(2'd2, v); check("R8 idle abort ignored", v, 16'h0);
        check("R8 idle abort no irq", 16'(irq_done), 16'h0);

        // R11: abort after all bytes of the frame were read
        send(8'h31, 1, 0, 0, 0);
        send(8'h32, 0, 0, 0, 0);
        exp_data = '{8'h31, 8'h32};
        exp_flag = '{flag_of(0,0,0,0,0), flag_of(0,0,0,0,0)};
        pop_check(); pop_check();
        check("R11 no irq before abort", 16'(irq_done), 16'h0);
        abort_pulse();
        check("R11 irq on drained abort", 16'(irq_done), 16'h1);
        rd(2'd2, v); check("R11 summary", v, sum_of(2, 1, 0, 0, 0));
        check("R5 done cleared", 16'(irq_done), 16'h0);

        // R10: summary queue overflow
        for (int k = 0; k < 5; k++) send(8'(k + 8'h60), 1, 1, 0, 0);
        peek(2'd3, v); check("R10 overflow flagged", v, 16'h0025);
        rd(2'd3, v);
        peek(2'd3, v); check("R10 overflow cleared", v, 16'h0005);
        for (int k = 0; k < 5; k++) begin
            rd(2'd1, v); check("R1 overflow data", v, 16'(k + 8'h60));
            check("R4 done", 16'(irq_done), 16'h1);
            rd(2'd2, v); check("R10 kept summaries", v, (k < 4) ? sum_of(1,0,0,0,0) : 16'h0);
        end

        // random frames mixed with random draining
        for (int it = 0; it < 80; it++) begin
            int len, n;
            bit c, f;
            len = 1 + int'($urandom % 5);
            c = 1'($urandom % 2);
            f = (($urandom % 4) == 0);
            if (exp_data.size() + len <= 16 && exp_sum.size() < 4) begin
                for (int k = 0; k < len; k++) begin
                    logic [7:0] d;
                    d = 8'($urandom);
                    send(d, k == 0, k == len - 1, c, f);
                    exp_data.push_back(d);
                    exp_flag.push_back(flag_of(k == len - 1, 0, 0,
                        (k == len - 1) && c, (k == len - 1) && f));
                end
                exp_sum.push_back(sum_of(len, 0, 0, c, f));
            end
            n = int'($urandom % 7);
            for (int j = 0; j < n; j++) if (exp_data.size() != 0) pop_check();
        end
        while (exp_data.size() != 0) pop_check();
        check("R3 svc drained", 16'(irq_svc), 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule